// File: doc/BRIEF.md
# Atomic Commit Stage with Load-Reserved Tracking

This block is the last stage of a data-cache pipeline for atomic memory operations that have already hit. It takes the full cache line read in the preceding stage with the operation code, a 64-bit operand, a byte offset inside the line and a word-size flag. It then produces a read-modify-write result, a line-wide write with byte enables for the data array, and a response that carries the value held before modification. Misses never reach it; tag and state lookup and the arrays themselves sit outside.

Every accepted operation occupies the stage for two cycles. In the first cycle the arithmetic is done and `busy` holds the earlier stages. In the second cycle the write and the response are issued together. A new request may be accepted in that second cycle, so operations can issue back to back every two cycles.

Load-reserved and store-conditional share a single reservation. It holds a line address and a countdown. While the countdown is running, probes to the reserved line are held off, so a short reserved sequence can finish without being broken by coherence traffic and without blocking it forever.

Top module: `amo_commit_stage`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid` is high and `busy` is low. `busy` is then high for exactly the next cycle and low in the cycle after it.
- R2: `resp_valid` is high for exactly one cycle, the cycle right after the `busy` cycle. A request presented while `busy` is high is ignored: it produces no second `busy` cycle and no response.
- R3: Op codes are swap=0, add=1, and=2, or=3, xor=4, signed min=5, signed max=6, unsigned min=7, unsigned max=8. Each of these writes the combined result of old value and operand.
- R4: Min and max compare at the operation width. For 32-bit operations only the low 32 operand bits take part.
- R5: When `req_size64` is 0, offset bit 2 selects the upper (1) or lower (0) half of the 8-byte word chosen by bits [5:3]. Exactly those 4 byte enables are set, and the response is the old 32-bit value sign-extended to 64 bits.
- R6: When `req_size64` is 1, offset bits [5:3] select the 8-byte word and exactly its 8 byte enables are set. `wr_data` equals the input line everywhere else, and `wr_addr` is the request's line address.
- R7: The response of ops 0 to 8 and of load-reserved is the value held before modification.
- R8: Load-reserved (op 9) writes nothing. It reloads the countdown with `RSV_CYCLES` at the edge that ends its busy cycle and records the line address. The countdown then drops by one at every later edge, and the reservation is live while the countdown is nonzero.
- R9: Store-conditional (op 10) succeeds when, during its busy cycle, the reservation is live and holds the same line address. On success it writes the operand and responds 0.
- R10: A failing store-conditional writes nothing and responds 1. Every store-conditional, whether it succeeds or fails, ends the reservation.
- R11: `probe_hold` is high exactly when the reservation is live and `probe_addr` equals the reserved line address.
- R12: During and right after reset, `busy`, `resp_valid`, `wr_valid` and `probe_hold` are low and there is no reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Atomic request present |
| req_op | input | 4 | Operation code |
| req_addr | input | ADDR_W | Line address |
| req_off | input | log2(LINE_BYTES) | Byte offset of the word in the line |
| req_size64 | input | 1 | 1 for a 64-bit word, 0 for 32-bit |
| req_operand | input | 64 | Operand |
| req_line | input | 8*LINE_BYTES | Line data read in the previous stage |
| probe_addr | input | ADDR_W | Line address of an incoming probe |
| busy | output | 1 | Stall for earlier stages |
| wr_valid | output | 1 | Data-array write strobe |
| wr_addr | output | ADDR_W | Line address to write |
| wr_data | output | 8*LINE_BYTES | Line with the modified word merged in |
| wr_mask | output | LINE_BYTES | Byte enables |
| resp_valid | output | 1 | Response strobe |
| resp_data | output | 64 | Old value, or the store-conditional status |
| probe_hold | output | 1 | Probe to the reserved line must wait |

## Verification
Two things can land on the same cycle. The write and response of one operation can coincide with the acceptance of the next one. A load-reserved setting or a store-conditional clearing the reservation can also coincide with a probe lookup to that line. The bench issues requests back to back, so the next request sits on the inputs during the previous write cycle, and it samples `probe_hold` in that same cycle. It judges both against a reference that counts clock edges from the load-reserved and applies the clear of each store-conditional, so the reservation state seen by the probe and by the following store-conditional must agree edge for edge.

// File: rtl/amo_pkg.sv
package amo_pkg;

   typedef enum logic [3:0] {
      AMO_SWAP = 4'd0,
      AMO_ADD  = 4'd1,
      AMO_AND  = 4'd2,
      AMO_OR   = 4'd3,
      AMO_XOR  = 4'd4,
      AMO_MIN  = 4'd5,
      AMO_MAX  = 4'd6,
      AMO_MINU = 4'd7,
      AMO_MAXU = 4'd8,
      AMO_LR   = 4'd9,
      AMO_SC   = 4'd10
   } amo_op_e;

   // arithmetic and logic ops always modify memory
   function automatic logic amo_is_rmw(amo_op_e op);
      return (op <= AMO_MAXU);
   endfunction

endpackage

// File: rtl/amo_word_pick.sv
module amo_word_pick #(
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_BITS = LINE_BYTES * 8
) (
   input  logic [LINE_BITS-1:0] line,
   input  logic [OFF_W-1:0]     off,
   input  logic                 size64,
   output logic [63:0]          dword,
   output logic [63:0]          old_val
);
   localparam int DW_W = OFF_W - 3;

   logic [DW_W-1:0] dw_sel;
   logic [31:0]     half;

   assign dw_sel  = off[OFF_W-1:3];
   assign dword   = line[dw_sel*64 +: 64];
   assign half    = off[2] ? dword[63:32] : dword[31:0];
   assign old_val = size64 ? dword : {{32{half[31]}}, half};
endmodule

// File: rtl/amo_alu.sv
module amo_alu
   import amo_pkg::*;
(
   input  amo_op_e     op,
   input  logic        size64,
   input  logic [63:0] old_val,
   input  logic [63:0] operand,
   output logic [63:0] result
);
   logic [63:0] opnd;
   logic        lt_s;
   logic        lt_u;

   // sign extension keeps both signed and unsigned ordering of 32-bit values
   assign opnd = size64 ? operand : {{32{operand[31]}}, operand[31:0]};
   assign lt_s = $signed(old_val) < $signed(opnd);
   assign lt_u = old_val < opnd;

   always_comb begin
      unique case (op)
         AMO_SWAP: result = opnd;
         AMO_ADD:  result = old_val + opnd;
         AMO_AND:  result = old_val & opnd;
         AMO_OR:   result = old_val | opnd;
         AMO_XOR:  result = old_val ^ opnd;
         AMO_MIN:  result = lt_s ? old_val : opnd;
         AMO_MAX:  result = lt_s ? opnd : old_val;
         AMO_MINU: result = lt_u ? old_val : opnd;
         AMO_MAXU: result = lt_u ? opnd : old_val;
         AMO_SC:   result = opnd;
         default:  result = old_val;
      endcase
   end
endmodule

// File: rtl/amo_line_merge.sv
module amo_line_merge #(
   parameter int LINE_BYTES = 64,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int LINE_BITS = LINE_BYTES * 8,
   localparam int NDW       = LINE_BYTES / 8
) (
   input  logic [LINE_BITS-1:0]  line,
   input  logic [OFF_W-1:0]      off,
   input  logic                  size64,
   input  logic [63:0]           result,
   output logic [LINE_BITS-1:0]  merged,
   output logic [LINE_BYTES-1:0] mask
);
   for (genvar d = 0; d < NDW; d++) begin : g_dw
      logic        hit;
      logic [63:0] old_dw;
      assign hit    = (off[OFF_W-1:3] == d[OFF_W-4:0]);
      assign old_dw = line[d*64 +: 64];

      always_comb begin
         if (!hit) begin
            merged[d*64 +: 64] = old_dw;
            mask[d*8 +: 8]     = 8'h00;
         end else if (size64) begin
            merged[d*64 +: 64] = result;
            mask[d*8 +: 8]     = 8'hFF;
         end else if (off[2]) begin
            merged[d*64 +: 64] = {result[31:0], old_dw[31:0]};
            mask[d*8 +: 8]     = 8'hF0;
         end else begin
            merged[d*64 +: 64] = {old_dw[63:32], result[31:0]};
            mask[d*8 +: 8]     = 8'h0F;
         end
      end
   end
endmodule

// File: rtl/amo_reservation.sv
module amo_reservation #(
   parameter int ADDR_W     = 36,
   parameter int RSV_CYCLES = 64,
   localparam int CNT_W     = $clog2(RSV_CYCLES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              set_lr,
   input  logic              clr_sc,
   input  logic [ADDR_W-1:0] set_addr,
   input  logic [ADDR_W-1:0] query_addr,
   input  logic [ADDR_W-1:0] probe_addr,
   output logic              query_hit,
   output logic              probe_hold
);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RSV_CYCLES);

   logic [CNT_W-1:0]  cnt_q;
   logic [ADDR_W-1:0] addr_q;
   logic              live;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         addr_q <= '0;
      end else if (set_lr) begin
         cnt_q  <= CNT_LOAD;
         addr_q <= set_addr;
      end else if (clr_sc) begin
         cnt_q  <= '0;
      end else if (cnt_q != '0) begin
         cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign live       = (cnt_q != '0);
   assign query_hit  = live && (addr_q == query_addr);
   assign probe_hold = live && (addr_q == probe_addr);
endmodule

// File: rtl/amo_commit_stage.sv
module amo_commit_stage
   import amo_pkg::*;
#(
   parameter int LINE_BYTES = 64,
   parameter int ADDR_W     = 36,
   parameter int RSV_CYCLES = 64
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              req_valid,
   input  logic [3:0]                        req_op,
   input  logic [ADDR_W-1:0]                 req_addr,
   input  logic [$clog2(LINE_BYTES)-1:0]     req_off,
   input  logic                              req_size64,
   input  logic [63:0]                       req_operand,
   input  logic [LINE_BYTES*8-1:0]           req_line,
   input  logic [ADDR_W-1:0]                 probe_addr,
   output logic                              busy,
   output logic                              wr_valid,
   output logic [ADDR_W-1:0]                 wr_addr,
   output logic [LINE_BYTES*8-1:0]           wr_data,
   output logic [LINE_BYTES-1:0]             wr_mask,
   output logic                              resp_valid,
   output logic [63:0]                       resp_data,
   output logic                              probe_hold
);
   localparam int OFF_W     = $clog2(LINE_BYTES);
   localparam int LINE_BITS = LINE_BYTES * 8;

   if (LINE_BYTES < 16 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
      $error("LINE_BYTES must be a power of two of at least 16");
   end
   if (RSV_CYCLES < 1) begin : g_bad_rsv
      $error("RSV_CYCLES must be at least 1");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("ADDR_W must be positive");
   end

   // captured request (first cycle)
   logic                 exec_q, wb_q;
   amo_op_e              op_q;
   logic [ADDR_W-1:0]    addr_q;
   logic [OFF_W-1:0]     off_q;
   logic                 size64_q;
   logic [63:0]          opnd_q;
   logic [LINE_BITS-1:0] line_q;

   // results (second cycle)
   logic                  wen_q;
   logic [LINE_BITS-1:0]  wdata_q;
   logic [LINE_BYTES-1:0] wmask_q;
   logic [63:0]           resp_q;

   logic                 accept;
   logic [63:0]          dword_c, old_c, res_c;
   logic [LINE_BITS-1:0] merged_c;
   logic [LINE_BYTES-1:0] mask_c;
   logic                 sc_ok;
   logic                 is_lr, is_sc;

   assign accept = req_valid && !exec_q;
   assign is_lr  = (op_q == AMO_LR);
   assign is_sc  = (op_q == AMO_SC);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exec_q <= 1'b0;
         wb_q   <= 1'b0;
      end else begin
         exec_q <= accept;
         wb_q   <= exec_q;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q     <= AMO_SWAP;
         addr_q   <= '0;
         off_q    <= '0;
         size64_q <= 1'b0;
         opnd_q   <= '0;
         line_q   <= '0;
      end else if (accept) begin
         op_q     <= amo_op_e'(req_op);
         addr_q   <= req_addr;
         off_q    <= req_off;
         size64_q <= req_size64;
         opnd_q   <= req_operand;
         line_q   <= req_line;
      end
   end

   amo_word_pick #(.LINE_BYTES(LINE_BYTES)) u_pick (
      .line    (line_q),
      .off     (off_q),
      .size64  (size64_q),
      .dword   (dword_c),
      .old_val (old_c)
   );

   amo_alu u_alu (
      .op      (op_q),
      .size64  (size64_q),
      .old_val (old_c),
      .operand (opnd_q),
      .result  (res_c)
   );

   amo_line_merge #(.LINE_BYTES(LINE_BYTES)) u_merge (
      .line    (line_q),
      .off     (off_q),
      .size64  (size64_q),
      .result  (res_c),
      .merged  (merged_c),
      .mask    (mask_c)
   );

   amo_reservation #(.ADDR_W(ADDR_W), .RSV_CYCLES(RSV_CYCLES)) u_rsv (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_lr     (exec_q && is_lr),
      .clr_sc     (exec_q && is_sc),
      .set_addr   (addr_q),
      .query_addr (addr_q),
      .probe_addr (probe_addr),
      .query_hit  (sc_ok),
      .probe_hold (probe_hold)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wen_q   <= 1'b0;
         wdata_q <= '0;
         wmask_q <= '0;
         resp_q  <= '0;
      end else if (exec_q) begin
         wen_q   <= amo_is_rmw(op_q) || (is_sc && sc_ok);
         wdata_q <= merged_c;
         wmask_q <= mask_c;
         if (is_sc) resp_q <= sc_ok ? 64'd0 : 64'd1;
         else       resp_q <= old_c;
      end
   end

   assign busy       = exec_q;
   assign resp_valid = wb_q;
   assign resp_data  = resp_q;
   assign wr_valid   = wb_q && wen_q;
   assign wr_addr    = addr_q;
   assign wr_data    = wdata_q;
   assign wr_mask    = wmask_q;

   logic unused_dw;
   assign unused_dw = ^dword_c;
endmodule

// File: rtl/amo_commit_checker.sv
module amo_commit_checker (
   input logic        clk,
   input logic        rst_n,
   input logic        req_valid,
   input logic [3:0]  req_op,
   input logic        busy,
   input logic        wr_valid,
   input logic        resp_valid,
   input logic [63:0] resp_data
);
   logic [3:0] op_seen;

   always_ff @(posedge clk) begin
      if (!rst_n)                  op_seen <= 4'd0;
      else if (req_valid && !busy) op_seen <= req_op;
   end

   a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy);

   a_r1_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   a_r2_resp_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> resp_valid);

   a_r2_resp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid);

   a_r2_resp_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(resp_valid) |-> $past(busy));

   a_r6_write_with_resp: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> resp_valid);

   a_r8_lr_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && op_seen == 4'd9) |-> !wr_valid);

   a_r10_sc_status: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && op_seen == 4'd10) |-> (resp_data <= 64'd1));

   a_r10_sc_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && op_seen == 4'd10 && resp_data == 64'd1) |-> !wr_valid);

   a_r9_sc_ok_writes: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && op_seen == 4'd10 && resp_data == 64'd0) |-> wr_valid);
endmodule

bind amo_commit_stage amo_commit_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .req_op     (req_op),
   .busy       (busy),
   .wr_valid   (wr_valid),
   .resp_valid (resp_valid),
   .resp_data  (resp_data)
);

// File: tb/sim_amo_commit_stage.sv
module sim_amo_commit_stage;
   localparam int PERIOD = 10;
   localparam int LB     = 64;
   localparam int AW     = 36;
   localparam int RSV    = 64;
   localparam int LBITS  = LB * 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic [3:0]       req_op = '0;
   logic [AW-1:0]    req_addr = '0;
   logic [5:0]       req_off = '0;
   logic             req_size64 = 1'b0;
   logic [63:0]      req_operand = '0;
   logic [LBITS-1:0] req_line = '0;
   logic [AW-1:0]    probe_addr = '0;
   logic             busy, wr_valid, resp_valid, probe_hold;
   logic [AW-1:0]    wr_addr;
   logic [LBITS-1:0] wr_data;
   logic [LB-1:0]    wr_mask;
   logic [63:0]      resp_data;

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;

   // reference reservation state
   bit          m_rsv = 1'b0;
   int          m_edge = 0;
   logic [AW-1:0] m_addr = '0;

   always #(PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   amo_commit_stage #(.LINE_BYTES(LB), .ADDR_W(AW), .RSV_CYCLES(RSV)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_off(req_off), .req_size64(req_size64),
      .req_operand(req_operand), .req_line(req_line), .probe_addr(probe_addr),
      .busy(busy), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
      .wr_mask(wr_mask), .resp_valid(resp_valid), .resp_data(resp_data),
      .probe_hold(probe_hold)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   function automatic bit live_at(int n);
      return m_rsv && ((n - m_edge) < RSV);
   endfunction

   function automatic logic [LBITS-1:0] rand_line();
      logic [LBITS-1:0] l;
      for (int i = 0; i < LBITS/32; i++) l[i*32 +: 32] = $urandom;
      return l;
   endfunction

   function automatic logic [63:0] ref_old(logic [LBITS-1:0] l, logic [5:0] off, bit w64);
      logic [63:0] d;
      logic [31:0] h;
      d = l[off[5:3]*64 +: 64];
      h = off[2] ? d[63:32] : d[31:0];
      return w64 ? d : {{32{h[31]}}, h};
   endfunction

   function automatic logic [63:0] ref_new(int op, bit w64, logic [63:0] a, logic [63:0] b);
      logic signed [63:0] sa, sb;
      logic signed [31:0] ta, tb;
      logic [31:0] ua, ub, r32;
      if (w64) begin
         sa = a; sb = b;
         case (op)
            0: return b;
            1: return a + b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            5: return (sa < sb) ? a : b;
            6: return (sa > sb) ? a : b;
            7: return (a < b) ? a : b;
            8: return (a > b) ? a : b;
            default: return b;
         endcase
      end
      ua = a[31:0]; ub = b[31:0]; ta = ua; tb = ub;
      case (op)
         0: r32 = ub;
         1: r32 = ua + ub;
         2: r32 = ua & ub;
         3: r32 = ua | ub;
         4: r32 = ua ^ ub;
         5: r32 = (ta < tb) ? ua : ub;
         6: r32 = (ta > tb) ? ua : ub;
         7: r32 = (ua < ub) ? ua : ub;
         8: r32 = (ua > ub) ? ua : ub;
         default: r32 = ub;
      endcase
      return {32'd0, r32};
   endfunction

   task automatic probe_chk(input logic [AW-1:0] pa);
      probe_addr = pa;
      #1;
      chk(probe_hold == (live_at(cyc) && pa == m_addr), "R11 probe_hold", 64'(probe_hold),
          64'(live_at(cyc) && pa == m_addr));
   endtask

   // called at a negedge; leaves at the negedge of the write cycle
   task automatic do_amo(input int op, input logic [AW-1:0] a, input logic [5:0] off,
                         input bit w64, input logic [63:0] opnd, input logic [LBITS-1:0] l,
                         input bit junk_while_busy);
      int es;
      bit sc_ok, exp_wr;
      logic [63:0] oldv, newv, exp_resp;
      logic [LBITS-1:0] exp_line;
      logic [LB-1:0] exp_mask;
      int base, nb;
      req_valid = 1'b1; req_op = 4'(op); req_addr = a; req_off = off;
      req_size64 = w64; req_operand = opnd; req_line = l;
      @(posedge clk); @(negedge clk);
      es = cyc;
      chk(busy == 1'b1, "R1 busy in compute cycle", 64'(busy), 64'd1);
      chk(resp_valid == 1'b0, "R2 no response in compute cycle", 64'(resp_valid), 64'd0);
      sc_ok = live_at(es) && (m_addr == a);
      if (junk_while_busy) begin
         req_op = 4'd1; req_addr = a + 1; req_operand = ~opnd; req_line = ~l;
      end else begin
         req_valid = 1'b0;
      end
      oldv = ref_old(l, off, w64);
      newv = ref_new(op, w64, oldv, opnd);
      nb   = w64 ? 8 : 4;
      base = w64 ? {off[5:3], 3'b000} : {off[5:2], 2'b00};
      exp_mask = '0; exp_line = l;
      for (int i = 0; i < nb; i++) begin
         exp_mask[base+i] = 1'b1;
         exp_line[(base+i)*8 +: 8] = newv[i*8 +: 8];
      end
      if (op == 10) begin
         exp_wr = sc_ok;
         exp_resp = sc_ok ? 64'd0 : 64'd1;
      end else begin
         exp_wr = (op <= 8);
         exp_resp = oldv;
      end
      @(posedge clk); @(negedge clk);
      req_valid = 1'b0;
      if (op == 9) begin m_rsv = 1'b1; m_edge = es + 1; m_addr = a; end
      if (op == 10) m_rsv = 1'b0;
      chk(resp_valid == 1'b1, "R2 response cycle", 64'(resp_valid), 64'd1);
      chk(busy == 1'b0, "R1 busy drops", 64'(busy), 64'd0);
      chk(resp_data == exp_resp,
          (op == 10) ? "R9/R10 sc status" : (op == 9) ? "R8 lr old value" :
          w64 ? "R7 old value" : "R5 sign-extended old value", resp_data, exp_resp);
      chk(wr_valid == exp_wr, (op == 9) ? "R8 lr no write" : (op == 10) ? "R10 sc write strobe" :
          "R3 write strobe", 64'(wr_valid), 64'(exp_wr));
      if (exp_wr) begin
         chk(wr_mask == exp_mask, w64 ? "R6 byte enables" : "R5 byte enables",
             64'(wr_mask), 64'(exp_mask));
         chk(wr_data == exp_line, (op >= 5 && op <= 8) ? "R4 min/max data" : "R3 write data",
             wr_data[base*8 +: 64], exp_line[base*8 +: 64]);
         chk(wr_addr == a, "R6 write address", 64'(wr_addr), 64'(a));
      end
      probe_chk(a);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         chk(resp_valid == 1'b0 && busy == 1'b0, "R2 quiet when idle", 64'({busy, resp_valid}), 64'd0);
         probe_chk(AW'($urandom_range(0, 3)));
      end
   endtask

   initial begin
      #(PERIOD * 200000);
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [LBITS-1:0] ln;
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      chk(busy == 0 && resp_valid == 0 && wr_valid == 0 && probe_hold == 0, "R12 reset outputs",
          64'({busy, resp_valid, wr_valid, probe_hold}), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      probe_chk('0);

      ln = rand_line();
      do_amo(1, 36'h10, 6'd40, 1'b1, 64'h1234_5678_9abc_def0, ln, 1'b0);
      do_amo(5, 36'h11, 6'd44, 1'b0, 64'h0000_0000_8000_0001, ln, 1'b0);
      do_amo(8, 36'h11, 6'd0,  1'b0, 64'hffff_ffff_ffff_fffe, ln, 1'b0);
      do_amo(6, 36'h12, 6'd8,  1'b1, 64'h8000_0000_0000_0000, ln, 1'b0);

      // R2: junk held during the busy cycle must not start a second op
      do_amo(4, 36'h13, 6'd16, 1'b1, 64'h5555, ln, 1'b1);
      idle(2);

      // R8/R9: reserve then succeed back to back
      do_amo(9, 36'h7, 6'd0, 1'b1, 64'd0, ln, 1'b0);
      do_amo(10, 36'h7, 6'd0, 1'b1, 64'hdead_beef, ln, 1'b0);
      idle(1);
      // R10: wrong line fails and clears
      do_amo(9, 36'h3, 6'd24, 1'b1, 64'd0, ln, 1'b0);
      do_amo(10, 36'h4, 6'd24, 1'b1, 64'h1, ln, 1'b0);
      do_amo(10, 36'h3, 6'd24, 1'b1, 64'h1, ln, 1'b0);
      // R8/R11: reservation expires after RSV cycles
      do_amo(9, 36'h2, 6'd32, 1'b0, 64'd0, ln, 1'b0);
      idle(RSV + 4);
      do_amo(10, 36'h2, 6'd32, 1'b0, 64'h7, ln, 1'b0);
      // reserve, wait just under the limit, then succeed
      do_amo(9, 36'h1, 6'd4, 1'b0, 64'd0, ln, 1'b0);
      idle(RSV - 4);
      do_amo(10, 36'h1, 6'd4, 1'b0, 64'h77, ln, 1'b0);

      for (int it = 0; it < 500; it++) begin
         int op;
         bit w;
         logic [5:0] o;
         op = $urandom_range(0, 10);
         if ($urandom_range(0, 3) == 0) op = 9 + $urandom_range(0, 1);
         w = $urandom_range(0, 1);
         o = 6'($urandom);
         o = w ? {o[5:3], 3'b000} : {o[5:2], 2'b00};
         do_amo(op, AW'($urandom_range(0, 3)), o, w, {$urandom, $urandom}, rand_line(),
                $urandom_range(0, 7) == 0);
         if ($urandom_range(0, 1) == 1) idle($urandom_range(0, 20));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
   end
endmodule